// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words and returns their product in the same format, with fixed latency of two clock cycles. Each operand word is laid out as a sign bit (bit 31), an 8-bit biased exponent (bits 30:23, bias 127) and a 23-bit fraction (bits 22:0) that carries an implied leading one for ordinary numbers. Ordinary numbers have exponent fields 1 to 254, which gives unbiased exponents from -126 to 127.

The first stage splits each operand into its fields and classifies it. It restores the implied one, multiplies the two 24-bit significands, forms the product sign by XOR and forms the product exponent as the sum of the operand exponents minus one bias. The second stage brings the product, which lies in [1,4), back into [1,2) with at most one right shift. It then rounds to nearest with ties to even, checks the exponent range and packs the result word. Zero, infinity and not-a-number operands are handled directly. Denormal operands are read as zero of the same sign, and results below the smallest normal magnitude are flushed to zero. A new operand pair may be presented on every cycle.

Top module: `fpm_mul32`

## Requirements
- R1: The result and flags for an operand pair applied before clock edge N appear after edge N+1 (two-cycle latency), a new pair is accepted every cycle, and while rst_n is low at a clock edge the result and all three flags are cleared to 0.
- R2: For every result that is not a not-a-number, result bit 31 equals the XOR of bit 31 of the two operands.
- R3: For two ordinary operands (exponent fields 1..254) whose product is in range, the result equals the exact product rounded to nearest with ties to even: exponent field in bits 30:23 with bias 127, fraction in bits 22:0, and all flags 0.
- R4: When the bits of the exact product below the kept fraction are exactly one half of a unit in the last place, the fraction is rounded to the neighbour whose least significant bit is 0.
- R5: When rounding carries out of the fraction, the fraction becomes 0 and the exponent field increases by one.
- R6: When the rounded exponent field of a finite nonzero product would be 255 or more, the result is infinity with the product sign (magnitude bits 30:0 = 0x7F800000) and flag_overflow is 1.
- R7: When the rounded exponent field of a finite nonzero product would be 0 or less, the result is zero with the product sign (bits 30:0 all 0) and flag_underflow is 1.
- R8: An operand with exponent field 0 (true zero, or a denormal with a nonzero fraction) counts as zero: multiplied by any finite operand it yields zero with the product sign and all flags 0.
- R9: An operand with exponent field 255 and fraction 0 is infinity: multiplied by infinity or by a nonzero finite operand it yields infinity with the product sign and all flags 0.
- R10: A not-a-number operand (exponent field 255, nonzero fraction) or the product of infinity and zero yields the word 0x7FC00000 with flag_invalid 1.
- R11: At most one of flag_invalid, flag_overflow and flag_underflow is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| result | output | 32 | Product word, two cycles after its operands |
| flag_invalid | output | 1 | Invalid operation (not-a-number input or infinity times zero) |
| flag_overflow | output | 1 | Product magnitude too large, result is infinity |
| flag_underflow | output | 1 | Product magnitude below smallest normal, result is zero |

## Verification
On every cycle the assertions check the relations between the flags and the result word: the canonical not-a-number under the invalid flag, infinity magnitude under overflow, zero magnitude under underflow, at most one flag at a time, and the result sign following the operand signs of two cycles before. They also check that the significand product of two normal operands lands in [1,4) and that a rounding carry leaves a zero fraction. Whether the value is the correctly rounded product can only be shown by the bench's scenarios: a model built on exact double-precision products for many ordinary operand pairs, directed tie and carry cases, the special-operand table, and a back-to-back stream that pins down the latency.

// File: rtl/fpm_pkg.sv
// Package fpm_pkg
// Shared widths, derived constants and types of the single-precision
// multiplier. Assumes the binary32 word layout: sign, biased exponent,
// fraction with an implied leading one.
package fpm_pkg;
    parameter int EXP_W  = 8;                      // exponent field width
    parameter int FRAC_W = 23;                     // stored fraction width
    localparam int WORD_W = 1 + EXP_W + FRAC_W;    // full word width
    localparam int SIG_W  = FRAC_W + 1;            // significand with hidden one
    localparam int PROD_W = 2 * SIG_W;             // significand product width
    localparam int EXT_W  = EXP_W + 3;             // signed exponent working width
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP = (1 << EXP_W) - 1;     // all-ones exponent field

    // Operand class after unpacking
    typedef enum logic [1:0] {
        CL_NUM  = 2'd0,   // ordinary number
        CL_ZERO = 2'd1,   // zero or flushed denormal
        CL_INF  = 2'd2,   // infinity
        CL_NAN  = 2'd3    // not-a-number
    } opnd_cls_e;

    // Outcome class of the whole product, decided before rounding
    typedef enum logic [1:0] {
        PR_FINITE = 2'd0, // needs normalise and round
        PR_ZERO   = 2'd1, // exact signed zero
        PR_INF    = 2'd2, // exact signed infinity
        PR_QNAN   = 2'd3  // canonical quiet NaN, invalid
    } prod_cls_e;

    typedef struct packed {
        logic               sign;
        logic [EXP_W-1:0]   expo;
        logic [SIG_W-1:0]   sig;
        opnd_cls_e          cls;
    } opnd_t;

    // Canonical quiet NaN: exponent all ones, top fraction bit set
    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
endpackage

// File: rtl/fpm_unpack.sv
// Module fpm_unpack
// Splits one operand word into sign, exponent and significand, restores
// the hidden one for ordinary numbers and classifies the operand.
// Assumes denormals are to be treated as zero (significand cleared).
module fpm_unpack
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output opnd_t             opnd
);
    logic [EXP_W-1:0]  fld_exp;
    logic [FRAC_W-1:0] fld_frac;
    logic              exp_zero;
    logic              exp_ones;

    assign fld_exp  = word[WORD_W-2 -: EXP_W];
    assign fld_frac = word[FRAC_W-1:0];
    assign exp_zero = (fld_exp == '0);
    assign exp_ones = (fld_exp == EXP_W'(EXP_TOP));

    // Classify the operand and build its significand
    always_comb begin
        opnd.sign = word[WORD_W-1];
        opnd.expo = fld_exp;
        opnd.sig  = {1'b1, fld_frac};
        opnd.cls  = CL_NUM;
        if (exp_zero) begin
            opnd.cls = CL_ZERO;
            opnd.sig = '0;
        end else if (exp_ones) begin
            opnd.cls = (fld_frac == '0) ? CL_INF : CL_NAN;
        end
    end
endmodule

// File: rtl/fpm_sigmul.sv
// Module fpm_sigmul
// Unsigned product of two significands. Assumes each input is either
// zero or has its top bit set, so a nonzero product lies in [1,4).
module fpm_sigmul
    import fpm_pkg::*;
(
    input  logic [SIG_W-1:0]  sig_a,
    input  logic [SIG_W-1:0]  sig_b,
    output logic [PROD_W-1:0] prod
);
    // Full-width multiply of the two significands
    always_comb begin
        prod = PROD_W'(sig_a) * PROD_W'(sig_b);
    end

    // R3: two normal significands give a product with one of its top two bits set
    always_comb begin
        if (sig_a[SIG_W-1] && sig_b[SIG_W-1])
            a_r3_prod_range: assert (prod[PROD_W-1:PROD_W-2] != 2'b00);
    end
endmodule

// File: rtl/fpm_round_pack.sv
// Module fpm_round_pack
// Normalises a significand product in [1,4) with at most one right shift,
// rounds to nearest-even using guard, round and sticky bits, checks the
// exponent range and packs the result word with its flags.
// Assumes exp_sum already holds ea + eb - bias as a signed value.
module fpm_round_pack
    import fpm_pkg::*;
(
    input  logic                    sign,
    input  logic signed [EXT_W-1:0] exp_sum,
    input  logic [PROD_W-1:0]       prod,
    input  prod_cls_e               pcls,
    output logic [WORD_W-1:0]       word,
    output logic                    flg_inv,
    output logic                    flg_ovf,
    output logic                    flg_unf
);
    logic                    top_bit;
    logic [FRAC_W-1:0]       mant;
    logic                    g_bit;
    logic                    r_bit;
    logic                    s_bit;
    logic                    rnd_up;
    logic                    rnd_cy;
    logic [FRAC_W-1:0]       mant_r;
    logic signed [EXT_W-1:0] exp_n;
    logic signed [EXT_W-1:0] exp_r;

    assign top_bit = prod[PROD_W-1];

    // Single-step normalise: pick fraction and rounding bits by the top bit
    always_comb begin
        if (top_bit) begin
            mant  = prod[PROD_W-2 -: FRAC_W];
            g_bit = prod[SIG_W-1];
            r_bit = prod[SIG_W-2];
            s_bit = |prod[SIG_W-3:0];
            exp_n = exp_sum + EXT_W'(1);
        end else begin
            mant  = prod[PROD_W-3 -: FRAC_W];
            g_bit = prod[SIG_W-2];
            r_bit = prod[SIG_W-3];
            s_bit = |prod[SIG_W-4:0];
            exp_n = exp_sum;
        end
    end

    // Round to nearest, ties to even; a carry-out renormalises
    always_comb begin
        rnd_up           = g_bit & (r_bit | s_bit | mant[0]);
        {rnd_cy, mant_r} = {1'b0, mant} + (FRAC_W + 1)'(rnd_up);
        exp_r            = exp_n + EXT_W'(rnd_cy);
    end

    // Select the packed word and flags by product class and range
    always_comb begin
        word    = '0;
        flg_inv = 1'b0;
        flg_ovf = 1'b0;
        flg_unf = 1'b0;
        unique case (pcls)
            PR_QNAN: begin
                word    = QNAN_WORD;
                flg_inv = 1'b1;
            end
            PR_INF:  word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            PR_ZERO: word = {sign, {(WORD_W-1){1'b0}}};
            default: begin
                if (int'(exp_r) >= EXP_TOP) begin
                    word    = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                    flg_ovf = 1'b1;
                end else if (int'(exp_r) <= 0) begin
                    word    = {sign, {(WORD_W-1){1'b0}}};
                    flg_unf = 1'b1;
                end else begin
                    word = {sign, exp_r[EXP_W-1:0], mant_r};
                end
            end
        endcase
    end

    // R5: a rounding carry out of the fraction leaves an all-zero fraction
    always_comb begin
        if (rnd_cy)
            a_r5_carry_zero_frac: assert (mant_r == '0);
    end
endmodule

// File: rtl/fpm_mul32.sv
// Module fpm_mul32
// Two-stage single-precision multiplier. Stage 1 unpacks both operands,
// multiplies significands, forms sign and exponent and classifies the
// product; stage 2 normalises, rounds and packs into the output register.
// Assumes a synchronous active-low reset; fixed latency of two cycles.
module fpm_mul32
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] result,
    output logic              flag_invalid,
    output logic              flag_overflow,
    output logic              flag_underflow
);
    localparam int N_OPS = 2;

    logic [WORD_W-1:0]       op_word [N_OPS];
    opnd_t                   opnd    [N_OPS];
    logic [PROD_W-1:0]       prod_c;
    logic                    sign_c;
    logic signed [EXT_W-1:0] exp_c;
    prod_cls_e               pcls_c;

    logic                    sign_q;
    logic signed [EXT_W-1:0] exp_q;
    logic [PROD_W-1:0]       prod_q;
    prod_cls_e               pcls_q;

    logic [WORD_W-1:0]       word_c;
    logic                    inv_c;
    logic                    ovf_c;
    logic                    unf_c;
    logic [1:0]              warm_q;

    assign op_word[0] = op_a;
    assign op_word[1] = op_b;

    // One unpacker per operand
    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_unpack
        fpm_unpack u_unpack (
            .word (op_word[gi]),
            .opnd (opnd[gi])
        );
    end

    fpm_sigmul u_sigmul (
        .sig_a (opnd[0].sig),
        .sig_b (opnd[1].sig),
        .prod  (prod_c)
    );

    // Product sign, biased exponent sum and product class
    always_comb begin
        sign_c = opnd[0].sign ^ opnd[1].sign;
        exp_c  = $signed({{(EXT_W-EXP_W){1'b0}}, opnd[0].expo})
               + $signed({{(EXT_W-EXP_W){1'b0}}, opnd[1].expo})
               - EXT_W'(BIAS);
        if (opnd[0].cls == CL_NAN || opnd[1].cls == CL_NAN)
            pcls_c = PR_QNAN;
        else if ((opnd[0].cls == CL_INF && opnd[1].cls == CL_ZERO) ||
                 (opnd[0].cls == CL_ZERO && opnd[1].cls == CL_INF))
            pcls_c = PR_QNAN;
        else if (opnd[0].cls == CL_INF || opnd[1].cls == CL_INF)
            pcls_c = PR_INF;
        else if (opnd[0].cls == CL_ZERO || opnd[1].cls == CL_ZERO)
            pcls_c = PR_ZERO;
        else
            pcls_c = PR_FINITE;
    end

    // Stage 1 register: product, sign, exponent and class
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign_q <= 1'b0;
            exp_q  <= '0;
            prod_q <= '0;
            pcls_q <= PR_ZERO;
        end else begin
            sign_q <= sign_c;
            exp_q  <= exp_c;
            prod_q <= prod_c;
            pcls_q <= pcls_c;
        end
    end

    fpm_round_pack u_round_pack (
        .sign    (sign_q),
        .exp_sum (exp_q),
        .prod    (prod_q),
        .pcls    (pcls_q),
        .word    (word_c),
        .flg_inv (inv_c),
        .flg_ovf (ovf_c),
        .flg_unf (unf_c)
    );

    // Stage 2 register: packed result and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result         <= '0;
            flag_invalid   <= 1'b0;
            flag_overflow  <= 1'b0;
            flag_underflow <= 1'b0;
        end else begin
            result         <= word_c;
            flag_invalid   <= inv_c;
            flag_overflow  <= ovf_c;
            flag_underflow <= unf_c;
        end
    end

    // Cycles since reset, saturating, for the two-cycle sign check
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm_q <= 2'd0;
        else if (warm_q != 2'd3)
            warm_q <= warm_q + 2'd1;
    end

    // R10: invalid flag comes with the canonical quiet NaN
    a_r10_invalid_qnan: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid |-> result == QNAN_WORD);

    // R6: overflow comes with an infinite magnitude
    a_r6_overflow_inf: assert property (@(posedge clk) disable iff (!rst_n)
        flag_overflow |-> result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});

    // R7: underflow comes with a zero magnitude
    a_r7_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flag_underflow |-> result[WORD_W-2:0] == '0);

    // R11: never more than one flag
    a_r11_flags_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_invalid, flag_overflow, flag_underflow}));

    // R2: result sign follows the operand signs of two cycles before
    a_r2_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2 && !flag_invalid) |->
            result[WORD_W-1] == $past(op_a[WORD_W-1] ^ op_b[WORD_W-1], 2));
endmodule

// File: tb/sim_fpm_mul32.sv
// Directed bench for fpm_mul32: one task per scenario, each checking itself.
module sim_fpm_mul32;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] result;
    logic        flag_invalid, flag_overflow, flag_underflow;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] lcg = 32'h1234_5678;

    fpm_mul32 u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .result(result), .flag_invalid(flag_invalid),
        .flag_overflow(flag_overflow), .flag_underflow(flag_underflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Compare result word and flags {invalid, overflow, underflow}
    task automatic check(input string tag, input logic [31:0] exp_w, input logic [2:0] exp_f);
        logic [2:0] got_f;
        got_f = {flag_invalid, flag_overflow, flag_underflow};
        checks++;
        if (result !== exp_w || got_f !== exp_f) begin
            errors++;
            $display("FAIL %s: got %08h flags %03b, expected %08h flags %03b",
                     tag, result, got_f, exp_w, exp_f);
        end
    endtask

    // Apply one pair, wait two edges, sample away from the edge
    task automatic apply(input string tag, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] exp_w, input logic [2:0] exp_f);
        @(negedge clk);
        op_a = a;
        op_b = b;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(tag, exp_w, exp_f);
    endtask

    // Reference for ordinary operands: exact product in double, rounded here
    function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] w, output logic [2:0] f);
        real         ra, rb;
        logic [63:0] d;
        logic [22:0] keep;
        logic [28:0] rem;
        logic        up, cy;
        int          e;
        ra = $bitstoreal({a[31], 11'(int'(a[30:23]) + 896), a[22:0], 29'd0});
        rb = $bitstoreal({b[31], 11'(int'(b[30:23]) + 896), b[22:0], 29'd0});
        d = $realtobits(ra * rb);
        keep = d[51:29];
        rem  = d[28:0];
        up = (rem > 29'h1000_0000) || (rem == 29'h1000_0000 && keep[0]);
        {cy, keep} = {1'b0, keep} + 24'(up);
        e = int'(d[62:52]) - 896 + int'(cy);
        if (e >= 255) begin
            w = {d[63], 8'hFF, 23'd0}; f = 3'b010;
        end else if (e <= 0) begin
            w = {d[63], 31'd0}; f = 3'b001;
        end else begin
            w = {d[63], 8'(e), keep}; f = 3'b000;
        end
    endfunction

    // R1: reset state while inputs are busy
    task automatic t_reset;
        op_a = 32'h4040_0000;
        op_b = 32'h7FC0_0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset clears outputs", 32'h0, 3'b000);
        rst_n = 1'b1;
    endtask

    // R3 R2: simple exact products with both signs
    task automatic t_basic;
        apply("R3 1.0*1.0", 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 3'b000);
        apply("R3 1.5*1.5", 32'h3FC0_0000, 32'h3FC0_0000, 32'h4010_0000, 3'b000);
        apply("R2 -3*2", 32'hC040_0000, 32'h4000_0000, 32'hC0C0_0000, 3'b000);
        apply("R2 -2*-0.5", 32'hC000_0000, 32'hBF00_0000, 32'h3F80_0000, 3'b000);
    endtask

    // R4 R5: halfway ties and rounding carry
    task automatic t_round;
        apply("R4 tie odd rounds up", 32'h3F80_0001, 32'h3FC0_0000, 32'h3FC0_0002, 3'b000);
        apply("R4 tie even stays", 32'h3F80_0003, 32'h3FC0_0000, 32'h3FC0_0004, 3'b000);
        apply("R5 carry renormalises", 32'h3FFF_FFFE, 32'h3F80_0001, 32'h4000_0000, 3'b000);
    endtask

    // R6 R7: range limits
    task automatic t_range;
        apply("R6 overflow pos", 32'h7F7F_FFFF, 32'h4000_0000, 32'h7F80_0000, 3'b010);
        apply("R6 overflow neg", 32'hFF7F_FFFF, 32'h4000_0000, 32'hFF80_0000, 3'b010);
        apply("R7 underflow pos", 32'h0080_0000, 32'h3F00_0000, 32'h0000_0000, 3'b001);
        apply("R7 underflow neg", 32'h8080_0000, 32'h3F00_0000, 32'h8000_0000, 3'b001);
        apply("R3 min normal kept", 32'h0100_0000, 32'h3F00_0000, 32'h0080_0000, 3'b000);
    endtask

    // R8 R9 R10: special operands
    task automatic t_special;
        apply("R8 zero*one", 32'h0000_0000, 32'h3F80_0000, 32'h0000_0000, 3'b000);
        apply("R8 -zero*one", 32'h8000_0000, 32'h3F80_0000, 32'h8000_0000, 3'b000);
        apply("R8 denormal flushed", 32'h0000_0001, 32'h7F00_0000, 32'h0000_0000, 3'b000);
        apply("R8 denormal*neg", 32'h0040_0000, 32'hC000_0000, 32'h8000_0000, 3'b000);
        apply("R9 inf*-2", 32'h7F80_0000, 32'hC000_0000, 32'hFF80_0000, 3'b000);
        apply("R9 inf*inf", 32'hFF80_0000, 32'hFF80_0000, 32'h7F80_0000, 3'b000);
        apply("R10 nan*one", 32'h7FC0_0001, 32'h3F80_0000, 32'h7FC0_0000, 3'b100);
        apply("R10 one*neg nan", 32'h3F80_0000, 32'hFF80_0001, 32'h7FC0_0000, 3'b100);
        apply("R10 inf*zero", 32'h7F80_0000, 32'h8000_0000, 32'h7FC0_0000, 3'b100);
        apply("R10 denormal*inf", 32'h0000_0005, 32'h7F80_0000, 32'h7FC0_0000, 3'b100);
    endtask

    // R1: back-to-back stream, each result exactly two cycles later
    task automatic t_stream;
        logic [31:0] va [4] = '{32'h3F80_0000, 32'h4000_0000, 32'h7F80_0000, 32'h4040_0000};
        logic [31:0] vb [4] = '{32'h4000_0000, 32'h4040_0000, 32'h0000_0000, 32'hC080_0000};
        logic [31:0] ve [4] = '{32'h4000_0000, 32'h40C0_0000, 32'h7FC0_0000, 32'hC140_0000};
        logic [2:0]  vf [4] = '{3'b000, 3'b000, 3'b100, 3'b000};
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 2) check("R1 stream latency", ve[i-2], vf[i-2]);
            if (i < 4) begin
                op_a = va[i];
                op_b = vb[i];
            end
        end
    endtask

    // R3 R6 R7: pseudo-random ordinary operands against the double model
    task automatic t_random;
        logic [31:0] a, b, w;
        logic [2:0]  f;
        for (int i = 0; i < 300; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            a = {lcg[31], 8'(1 + (lcg[30:8] % 254)), lcg[22:0] ^ {lcg[7:0], 15'h5A3C}};
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            b = {lcg[31], 8'(1 + (lcg[30:8] % 254)), lcg[22:0] ^ {lcg[9:0], 13'h1B7}};
            model(a, b, w, f);
            apply("R3 random vs model", a, b, w, f);
        end
    endtask

    initial begin
        t_reset();
        t_basic();
        t_round();
        t_range();
        t_special();
        t_stream();
        t_random();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule